// File: doc/BRIEF.md
# ECC Error Status and Interrupt Reporter

This block collects error-correction events from two memory sources, a RAM and a Flash array. Either source can report a single-bit error that was corrected or an error that could not be corrected. An 8-bit enable register selects which of these four event categories are recorded. The block keeps the most recent enabled event in an 8-bit status register whose flags are cleared by writing one. In the same cycle it captures the address and attribute byte of that event into read-only reporting registers. It drives five interrupt request lines, each formed from the enable bits and the status flags.

Only one status flag is ever set. A newly recorded event replaces the flag, the address and the attribute byte together, so the three always describe the same event. Software reads and writes the registers through a small port that has a 2-bit register select. Each source has a one-cycle event strobe, a kind bit, an address and an attribute byte.

Top module: `ecc_event_reporter`

## Requirements
- R1: After a synchronous reset, the enable, status, address and attribute registers read as zero and all five interrupt outputs are low.
- R2: The enable register (select 0) is 8 bits wide and fully read/write. A write takes effect on the next clock edge and can be read back from then on.
- R3: The status register is at select 1. Counting bit 0 as the MSB, its flag positions are: RAM corrected at bit 2 (value 0x20), Flash corrected at bit 3 (0x10), RAM noncorrectable at bit 6 (0x02) and Flash noncorrectable at bit 7 (0x01). The enable register uses the same positions. All other status bits read as zero.
- R4: An event whose category has its enable bit at 0 leaves the status, address and attribute registers unchanged.
- R5: An enabled event sets only its own flag and clears any other flag. At the same clock edge it loads that event's address (select 2) and its attribute byte (select 3, zero-extended).
- R6: Writing the status register clears each flag that has a 1 in the written data. A 0 bit leaves its flag unchanged. The address and attribute registers keep their values after a clear.
- R7: When several enabled events arrive in the same cycle, only one is recorded. The order of precedence is RAM noncorrectable, then Flash noncorrectable, then RAM corrected, then Flash corrected. An event kind bit of 1 means noncorrectable.
- R8: When an enabled event and a status write arrive in the same cycle, the event is recorded and the write has no effect on the status register.
- R9: irq_corrected = (RAM corrected enable AND its flag) OR (Flash corrected enable AND its flag).
- R10: irq_ram_fatal is the RAM noncorrectable enable ANDed with its flag. irq_flash_fatal is the same for Flash.
- R11: irq_fatal is the OR of irq_ram_fatal and irq_flash_fatal. irq_any is the OR of irq_corrected and irq_fatal.
- R12: Writes to the address (select 2) and attribute (select 3) registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 enable, 1 status, 2 address, 3 attribute |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| ram_evt | input | 1 | RAM event strobe, one cycle per event |
| ram_evt_uncorr | input | 1 | RAM event kind: 1 noncorrectable, 0 corrected |
| ram_evt_addr | input | 32 | RAM event address |
| ram_evt_attr | input | 8 | RAM event attributes |
| flash_evt | input | 1 | Flash event strobe, one cycle per event |
| flash_evt_uncorr | input | 1 | Flash event kind: 1 noncorrectable, 0 corrected |
| flash_evt_addr | input | 32 | Flash event address |
| flash_evt_attr | input | 8 | Flash event attributes |
| irq_corrected | output | 1 | Corrected-error interrupt |
| irq_ram_fatal | output | 1 | RAM noncorrectable interrupt |
| irq_flash_fatal | output | 1 | Flash noncorrectable interrupt |
| irq_fatal | output | 1 | Combined noncorrectable interrupt |
| irq_any | output | 1 | Any ECC interrupt |

## Verification
The assertions assume that each event strobe and its kind, address and attribute are valid in the same cycle. They also assume that a status write reaches the block only as a single-cycle strobe on select 1. No assertion depends on the address or attribute values being distinct. The stimulus drives every input from a negative clock edge and holds it for exactly one cycle. It uses distinct addresses and attribute bytes, so that a capture from the wrong source or from a stale event is visible. A random phase mixes events, enable changes and status writes in the same cycle, which reaches the precedence and event-beats-clear cases many times.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;

    localparam int ECC_ADDR_W = 32;
    localparam int ECC_ATTR_W = 8;
    localparam int ECC_REG_W  = 8;

    // flag positions inside logic [7:0] (MSB-first bit 2,3,6,7)
    localparam int POS_RAM_CORR   = 5;
    localparam int POS_FLASH_CORR = 4;
    localparam int POS_RAM_NC     = 1;
    localparam int POS_FLASH_NC   = 0;

    localparam logic [ECC_REG_W-1:0] FLAG_MASK =
        ECC_REG_W'((1 << POS_RAM_CORR) | (1 << POS_FLASH_CORR) |
                   (1 << POS_RAM_NC)   | (1 << POS_FLASH_NC));

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ADDR   = 2'd2,
        SEL_ATTR   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                  valid;
        logic [ECC_REG_W-1:0]  flag;
        logic [ECC_ADDR_W-1:0] addr;
        logic [ECC_ATTR_W-1:0] attr;
    } ecc_evt_t;

    function automatic logic [ECC_REG_W-1:0] pos_bit(input int pos);
        return ECC_REG_W'(1) << pos;
    endfunction

endpackage

// File: rtl/ecc_event_arbiter.sv
module ecc_event_arbiter
    import ecc_rpt_pkg::*;
(
    input  logic [ECC_REG_W-1:0]  enable,
    input  logic                  ram_evt,
    input  logic                  ram_uncorr,
    input  logic [ECC_ADDR_W-1:0] ram_addr,
    input  logic [ECC_ATTR_W-1:0] ram_attr,
    input  logic                  flash_evt,
    input  logic                  flash_uncorr,
    input  logic [ECC_ADDR_W-1:0] flash_addr,
    input  logic [ECC_ATTR_W-1:0] flash_attr,
    output ecc_evt_t              picked
);
    localparam int N_CAND = 4;

    ecc_evt_t cand [N_CAND];

    // candidates listed in precedence order, index 0 highest
    always_comb begin
        cand[0] = '{valid: ram_evt & ram_uncorr,     flag: pos_bit(POS_RAM_NC),
                    addr: ram_addr,   attr: ram_attr};
        cand[1] = '{valid: flash_evt & flash_uncorr, flag: pos_bit(POS_FLASH_NC),
                    addr: flash_addr, attr: flash_attr};
        cand[2] = '{valid: ram_evt & ~ram_uncorr,    flag: pos_bit(POS_RAM_CORR),
                    addr: ram_addr,   attr: ram_attr};
        cand[3] = '{valid: flash_evt & ~flash_uncorr, flag: pos_bit(POS_FLASH_CORR),
                    addr: flash_addr, attr: flash_attr};
    end

    always_comb begin
        picked = '0;
        for (int i = N_CAND - 1; i >= 0; i--) begin
            if (cand[i].valid && |(cand[i].flag & enable)) begin
                picked = cand[i];
            end
        end
    end

endmodule

// File: rtl/ecc_status_bank.sv
module ecc_status_bank
    import ecc_rpt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  ecc_evt_t              evt,
    input  logic                  clr_we,
    input  logic [ECC_REG_W-1:0]  clr_mask,
    output logic [ECC_REG_W-1:0]  flags,
    output logic [ECC_ADDR_W-1:0] cap_addr,
    output logic [ECC_ATTR_W-1:0] cap_attr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            cap_addr <= '0;
            cap_attr <= '0;
        end else if (evt.valid) begin
            flags    <= evt.flag & FLAG_MASK;
            cap_addr <= evt.addr;
            cap_attr <= evt.attr;
        end else if (clr_we) begin
            flags    <= flags & ~clr_mask;
        end
    end

    assert_one_flag_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags));

    assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
        evt.valid |=> (flags == ($past(evt.flag) & FLAG_MASK)) &&
                      (cap_addr == $past(evt.addr)) && (cap_attr == $past(evt.attr)));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!evt.valid && !clr_we) |=> $stable(flags) && $stable(cap_addr) && $stable(cap_attr));

    assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && clr_we) |=> (flags != '0));

    assert_clear_keeps_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (!evt.valid && clr_we) |=> $stable(cap_addr) && $stable(cap_attr));

endmodule

// File: rtl/ecc_irq_gen.sv
module ecc_irq_gen
    import ecc_rpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ECC_REG_W-1:0] enable,
    input  logic [ECC_REG_W-1:0] flags,
    output logic                 irq_corrected,
    output logic                 irq_ram_fatal,
    output logic                 irq_flash_fatal,
    output logic                 irq_fatal,
    output logic                 irq_any
);
    logic [ECC_REG_W-1:0] live;

    always_comb begin
        live            = enable & flags & FLAG_MASK;
        irq_corrected   = live[POS_RAM_CORR] | live[POS_FLASH_CORR];
        irq_ram_fatal   = live[POS_RAM_NC];
        irq_flash_fatal = live[POS_FLASH_NC];
        irq_fatal       = irq_ram_fatal | irq_flash_fatal;
        irq_any         = irq_corrected | irq_fatal;
    end

    assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (rst)
        irq_any |-> ($countones(flags) == 1));

    assert_corr_source_R9: assert property (@(posedge clk) disable iff (rst)
        irq_corrected |-> (flags[POS_RAM_CORR] | flags[POS_FLASH_CORR]));

    assert_fatal_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(irq_ram_fatal && irq_flash_fatal));

endmodule

// File: rtl/ecc_event_reporter.sv
module ecc_event_reporter
    import ecc_rpt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            reg_sel,
    input  logic                  reg_we,
    input  logic [7:0]            reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic                  ram_evt,
    input  logic                  ram_evt_uncorr,
    input  logic [31:0]           ram_evt_addr,
    input  logic [7:0]            ram_evt_attr,
    input  logic                  flash_evt,
    input  logic                  flash_evt_uncorr,
    input  logic [31:0]           flash_evt_addr,
    input  logic [7:0]            flash_evt_attr,
    output logic                  irq_corrected,
    output logic                  irq_ram_fatal,
    output logic                  irq_flash_fatal,
    output logic                  irq_fatal,
    output logic                  irq_any
);
    localparam int RD_W = (ECC_ADDR_W > ECC_REG_W) ? ECC_ADDR_W : ECC_REG_W;

    reg_sel_e              sel;
    logic [ECC_REG_W-1:0]  enable_q;
    logic [ECC_REG_W-1:0]  flags;
    logic [ECC_ADDR_W-1:0] cap_addr;
    logic [ECC_ATTR_W-1:0] cap_attr;
    ecc_evt_t              picked;
    logic                  wr_enable;
    logic                  wr_status;

    assign sel       = reg_sel_e'(reg_sel);
    assign wr_enable = reg_we && (sel == SEL_ENABLE);
    assign wr_status = reg_we && (sel == SEL_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
        end else if (wr_enable) begin
            enable_q <= reg_wdata;
        end
    end

    ecc_event_arbiter u_arb (
        .enable       (enable_q),
        .ram_evt      (ram_evt),
        .ram_uncorr   (ram_evt_uncorr),
        .ram_addr     (ram_evt_addr),
        .ram_attr     (ram_evt_attr),
        .flash_evt    (flash_evt),
        .flash_uncorr (flash_evt_uncorr),
        .flash_addr   (flash_evt_addr),
        .flash_attr   (flash_evt_attr),
        .picked       (picked)
    );

    ecc_status_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .evt      (picked),
        .clr_we   (wr_status),
        .clr_mask (reg_wdata),
        .flags    (flags),
        .cap_addr (cap_addr),
        .cap_attr (cap_attr)
    );

    ecc_irq_gen u_irq (
        .clk             (clk),
        .rst             (rst),
        .enable          (enable_q),
        .flags           (flags),
        .irq_corrected   (irq_corrected),
        .irq_ram_fatal   (irq_ram_fatal),
        .irq_flash_fatal (irq_flash_fatal),
        .irq_fatal       (irq_fatal),
        .irq_any         (irq_any)
    );

    always_comb begin
        unique case (sel)
            SEL_ENABLE: reg_rdata = RD_W'(enable_q);
            SEL_STATUS: reg_rdata = RD_W'(flags);
            SEL_ADDR:   reg_rdata = RD_W'(cap_addr);
            SEL_ATTR:   reg_rdata = RD_W'(cap_attr);
            default:    reg_rdata = '0;
        endcase
    end

    assert_enable_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_enable |=> (enable_q == $past(reg_wdata)));

    assert_unused_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (flags & ~FLAG_MASK) == '0);

    assert_disabled_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (!picked.valid && !wr_status) |=> $stable(flags));

endmodule

// File: tb/ecc_event_reporter_test.sv
module ecc_event_reporter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [31:0] reg_rdata;
    logic        ram_evt = 1'b0, ram_evt_uncorr = 1'b0;
    logic [31:0] ram_evt_addr = 32'd0;
    logic [7:0]  ram_evt_attr = 8'd0;
    logic        flash_evt = 1'b0, flash_evt_uncorr = 1'b0;
    logic [31:0] flash_evt_addr = 32'd0;
    logic [7:0]  flash_evt_attr = 8'd0;
    logic        irq_corrected, irq_ram_fatal, irq_flash_fatal, irq_fatal, irq_any;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    // reference state
    bit [7:0]  m_en, m_st, m_attr;
    bit [31:0] m_addr;

    always #10 clk = ~clk;

    ecc_event_reporter uut (
        .clk(clk), .rst(rst),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ram_evt(ram_evt), .ram_evt_uncorr(ram_evt_uncorr),
        .ram_evt_addr(ram_evt_addr), .ram_evt_attr(ram_evt_attr),
        .flash_evt(flash_evt), .flash_evt_uncorr(flash_evt_uncorr),
        .flash_evt_addr(flash_evt_addr), .flash_evt_attr(flash_evt_attr),
        .irq_corrected(irq_corrected), .irq_ram_fatal(irq_ram_fatal),
        .irq_flash_fatal(irq_flash_fatal), .irq_fatal(irq_fatal), .irq_any(irq_any)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
        end
    endtask

    function automatic bit [31:0] model_read(input bit [1:0] s);
        case (s)
            2'd0: return {24'd0, m_en};
            2'd1: return {24'd0, m_st};
            2'd2: return m_addr;
            default: return {24'd0, m_attr};
        endcase
    endfunction

    task automatic compare_all(input string tag);
        bit c, rf, ff;
        c  = (m_en[5] && m_st[5]) || (m_en[4] && m_st[4]);
        rf = m_en[1] && m_st[1];
        ff = m_en[0] && m_st[0];
        check({tag, " R9 irq_corrected"}, {31'd0, irq_corrected}, {31'd0, c});
        check({tag, " R10 irq_ram_fatal"}, {31'd0, irq_ram_fatal}, {31'd0, rf});
        check({tag, " R10 irq_flash_fatal"}, {31'd0, irq_flash_fatal}, {31'd0, ff});
        check({tag, " R11 irq_fatal"}, {31'd0, irq_fatal}, {31'd0, rf || ff});
        check({tag, " R11 irq_any"}, {31'd0, irq_any}, {31'd0, c || rf || ff});
        check({tag, " readback"}, reg_rdata, model_read(reg_sel));
    endtask

    // apply current inputs for one cycle, advance model, compare at negedge
    task automatic step(input string tag);
        bit [7:0] n_en, n_st;
        int order [4];
        bit vld [4];
        order = '{1, 0, 5, 4};
        vld   = '{ram_evt && ram_evt_uncorr, flash_evt && flash_evt_uncorr,
                  ram_evt && !ram_evt_uncorr, flash_evt && !flash_evt_uncorr};
        n_en = m_en;
        n_st = m_st;
        if (reg_we && reg_sel == 2'd0) n_en = reg_wdata;
        if (reg_we && reg_sel == 2'd1) n_st = m_st & ~reg_wdata;
        @(posedge clk);
        #1;
        if (rst) begin
            m_en = 0; m_st = 0; m_addr = 0; m_attr = 0;
        end else begin
            bit taken = 0;
            for (int i = 0; i < 4; i++) begin
                if (!taken && vld[i] && m_en[order[i]]) begin
                    taken = 1;
                    n_st = 8'd1 << order[i];
                    if (order[i] == 1 || order[i] == 5) begin
                        m_addr = ram_evt_addr; m_attr = ram_evt_attr;
                    end else begin
                        m_addr = flash_evt_addr; m_attr = flash_evt_attr;
                    end
                end
            end
            m_en = n_en;
            m_st = n_st;
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle();
        reg_we = 0; reg_wdata = 0;
        ram_evt = 0; ram_evt_uncorr = 0;
        flash_evt = 0; flash_evt_uncorr = 0;
    endtask

    task automatic wr(input bit [1:0] s, input bit [7:0] d, input string tag);
        idle(); reg_sel = s; reg_we = 1; reg_wdata = d; step(tag);
        idle();
    endtask

    task automatic rd(input bit [1:0] s, input string tag);
        idle(); reg_sel = s; step(tag);
    endtask

    task automatic read_all(input string tag);
        for (int s = 0; s < 4; s++) rd(2'(s), tag);
    endtask

    task automatic ev(input bit r, input bit ru, input bit f, input bit fu, input string tag);
        ram_evt = r; ram_evt_uncorr = ru;
        ram_evt_addr = $urandom; ram_evt_attr = 8'($urandom);
        flash_evt = f; flash_evt_uncorr = fu;
        flash_evt_addr = $urandom; flash_evt_attr = 8'($urandom);
        step(tag);
        idle();
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1;
        step("R1 reset");
        step("R1 reset");
        rst = 0;
        read_all("R1 post-reset");

        // disabled events ignored
        ev(1, 0, 1, 1, "R4 disabled");
        read_all("R4 after disabled");

        // enable full RW
        wr(2'd0, 8'hA5, "R2 write enable");
        rd(2'd0, "R2 readback");
        wr(2'd0, 8'h33, "R2 write enable all flags");
        rd(2'd0, "R2 readback 33");

        // each category position
        ev(1, 0, 0, 0, "R3 ram corrected 0x20");
        read_all("R3 R5 after ram corr");
        ev(0, 0, 1, 0, "R3 flash corrected 0x10");
        read_all("R5 overwrite flash corr");
        ev(1, 1, 0, 0, "R3 ram fatal 0x02");
        read_all("R5 ram fatal");
        ev(0, 0, 1, 1, "R3 flash fatal 0x01");
        read_all("R5 flash fatal");

        // read-only capture regs
        wr(2'd2, 8'hFF, "R12 write addr");
        wr(2'd3, 8'hFF, "R12 write attr");
        read_all("R12 after ro writes");

        // w1c
        wr(2'd1, 8'h00, "R6 write zero");
        wr(2'd1, 8'hFE, "R6 other bits");
        rd(2'd1, "R6 still set");
        wr(2'd1, 8'h01, "R6 clear flag");
        read_all("R6 capture kept");

        // precedence
        ev(1, 1, 1, 1, "R7 both fatal");
        read_all("R7 ram fatal wins");
        ev(1, 0, 1, 1, "R7 flash fatal over ram corr");
        read_all("R7 flash fatal");
        ev(1, 0, 1, 0, "R7 ram corr over flash corr");
        read_all("R7 ram corr");
        wr(2'd0, 8'h31, "R7 disable ram fatal");
        ev(1, 1, 1, 0, "R7 disabled top falls through");
        read_all("R7 flash corr");

        // event beats clear
        wr(2'd0, 8'h33, "R2 re-enable");
        reg_sel = 2'd1; reg_we = 1; reg_wdata = 8'hFF;
        ev(1, 1, 0, 0, "R8 event with clear");
        read_all("R8 event kept");

        // disabled category while flag pending
        wr(2'd0, 8'h13, "R4 disable ram corr");
        ev(1, 0, 0, 0, "R4 disabled while pending");
        read_all("R4 pending kept");
        wr(2'd0, 8'h00, "R9 enables off hides irq");
        rd(2'd1, "R10 flag remains");

        // random mix
        for (int n = 0; n < 2000; n++) begin
            reg_sel   = 2'($urandom);
            reg_we    = ($urandom % 4) == 0;
            reg_wdata = 8'($urandom);
            if (($urandom % 8) == 0) reg_wdata = 8'h33;
            ram_evt_uncorr = 1'($urandom);
            flash_evt_uncorr = 1'($urandom);
            ram_evt   = ($urandom % 3) == 0;
            flash_evt = ($urandom % 3) == 0;
            ram_evt_addr = $urandom; ram_evt_attr = 8'($urandom);
            flash_evt_addr = $urandom; flash_evt_attr = 8'($urandom);
            step("R5 R7 R8 random");
        end
        idle();
        read_all("R5 final");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule